// File: doc/BRIEF.md
# SPI Boot Stream Loader

This block brings a chip up from an external serial EEPROM or serial flash with no software running. After a start pulse it becomes the SPI master, drops chip select, issues a sequential read from address zero and parses the returned 8-bit boot image in a single burst. The image opens with a 16-bit key. Two clock-configuration bytes follow, then a run of reserved padding and a 32-bit entry point. The rest of the image is a chain of copy blocks, each made of a word count, a destination address and the data words.

Each 16-bit data word goes out through a one-cycle word-write port to consecutive word addresses. A block with a count of zero ends the image. The loader then releases chip select, raises `done_o` and presents the entry point. A bad key, or an entry point whose top byte is nonzero, stops the load and raises `error_o` instead.

Top module: `spi_boot_loader`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no start pulse, `cs_no` is 1, `sclk_o` is 0, and `done_o`, `error_o` and `wr_en_o` are 0.
- R2: The serial link idles with `sclk_o` low. `mosi_o` changes only on a rising `sclk_o` edge and `miso_i` is sampled on the falling edge. Characters are 8 bits, most significant bit first.
- R3: A one-cycle `start_i` pulse drives `cs_no` low. The loader then sends the read opcode 0x03 followed by zero address bytes: two when `addr24_i`=0 and three when `addr24_i`=1. `cs_no` stays low until the load ends.
- R4: The first two image bytes must be 0xAA and then 0x08 (key 0x08AA, low byte first). On any other pair the loader raises `error_o`, releases `cs_no`, writes nothing and reads no further bytes.
- R5: Image byte 3 is latched into `presc_o` and image byte 4 into `baud_o`.
- R6: Image bytes 5 through 18 are read and discarded. Their values have no effect on any output.
- R7: Image bytes 19 to 22 form the entry point in the order bits 23:16, 31:24, 7:0, 15:8. The result appears on `entry_o` when `done_o` rises.
- R8: If entry-point bits 31:24 (byte 20) are nonzero, the loader raises `error_o`, releases `cs_no` and stops after that byte.
- R9: Each block is a 16-bit word count (low byte first), then a 32-bit destination address (high word first, each word low byte first), then that many data words (low byte first). Each data word produces exactly one `wr_en_o` pulse, and the words go to consecutive addresses starting at the destination.
- R10: Any number of blocks may follow one another. A word count of zero ends the load: `cs_no` rises, `done_o` rises and the whole image has been read in one chip-select window.
- R11: `done_o` and `error_o` are never high together. Either one stays high until the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that begins a load |
| addr24_i | input | 1 | Memory address width: 0 = 16 bits, 1 = 24 bits |
| sclk_o | output | 1 | Serial clock, polarity 0, phase 1 |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to the memory |
| miso_i | input | 1 | Serial data from the memory |
| wr_en_o | output | 1 | Word write strobe |
| wr_addr_o | output | 32 | Word write address |
| wr_data_o | output | 16 | Word write data |
| done_o | output | 1 | Load finished |
| error_o | output | 1 | Load stopped on a bad key or bad entry point |
| entry_o | output | 32 | Entry point |
| presc_o | output | 8 | Captured low-speed clock prescaler byte |
| baud_o | output | 8 | Captured baud divider byte |

## Verification
A parser whose byte position is off by one shows up within one character time. The key check misfires, the entry point comes out with its bytes rotated, or the write scoreboard sees a word at the wrong address. A block-count or address slip shows on the next `wr_en_o`. A framing error in the serial engine corrupts the command header that the memory model captures, so it is seen in the first four bytes. The total number of serial clocks inside the chip-select window is compared with the image length, which exposes bytes that were read too early, too late or twice.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;
  localparam logic [7:0]  READ_OP    = 8'h03;
  localparam logic [15:0] BOOT_KEY   = 16'h08AA;
  localparam int          RSVD_BYTES = 14;
  localparam int          IDX_W      = $clog2(RSVD_BYTES + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_KEY, ST_CLK, ST_RSVD,
    ST_ENTRY, ST_CNT, ST_DEST, ST_DATA, ST_DONE, ST_ERR
  } ld_state_e;
endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int HALF_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  output logic       ready_o,
  output logic [7:0] rx_o,
  output logic       rx_valid_o,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic          busy_q, sclk_q, mosi_q, rxv_q;
  logic [7:0]    tx_sh, rx_sh, rx_q;
  logic [2:0]    bit_cnt;
  logic [CW-1:0] div_cnt;
  logic          tick;

  assign tick = (div_cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      mosi_q  <= 1'b0;
      rxv_q   <= 1'b0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_q    <= '0;
      bit_cnt <= '0;
      div_cnt <= '0;
    end else begin
      rxv_q <= 1'b0;
      if (!busy_q) begin
        if (go_i) begin
          busy_q  <= 1'b1;
          tx_sh   <= tx_i;
          div_cnt <= '0;
          bit_cnt <= '0;
        end
      end else if (tick) begin
        div_cnt <= '0;
        if (!sclk_q) begin
          // leading edge launches data (phase 1)
          sclk_q <= 1'b1;
          mosi_q <= tx_sh[7];
          tx_sh  <= {tx_sh[6:0], 1'b0};
        end else begin
          sclk_q  <= 1'b0;
          rx_sh   <= {rx_sh[6:0], miso_i};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            busy_q <= 1'b0;
            rxv_q  <= 1'b1;
            rx_q   <= {rx_sh[6:0], miso_i};
          end
        end
      end else begin
        div_cnt <= div_cnt + CW'(1);
      end
    end
  end

  assign ready_o    = !busy_q;
  assign rx_o       = rx_q;
  assign rx_valid_o = rxv_q;
  assign sclk_o     = sclk_q;
  assign mosi_o     = mosi_q;

  // R2
  sclk_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sclk_q);
  // R2
  mosi_hold_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_q) |-> $stable(mosi_q));
  // R3
  no_go_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !busy_q);
endmodule

// File: rtl/boot_stream_parser.sv
module boot_stream_parser
  import spi_boot_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        addr24_i,
  input  logic        ready_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_i,
  output logic        go_o,
  output logic [7:0]  tx_o,
  output logic        cs_no,
  output logic        wr_en_o,
  output logic [31:0] wr_addr_o,
  output logic [15:0] wr_data_o,
  output logic        done_o,
  output logic        error_o,
  output logic [31:0] entry_o,
  output logic [7:0]  presc_o,
  output logic [7:0]  baud_o
);
  ld_state_e        state_q;
  logic [IDX_W-1:0] idx_q, addr_last;
  logic             wait_q, reading;
  logic [7:0]       lo_q;
  logic [15:0]      cnt_q;
  logic [31:0]      dest_q, entry_q;

  assign reading   = (state_q != ST_IDLE) && (state_q != ST_DONE) && (state_q != ST_ERR);
  assign go_o      = reading && ready_i && !wait_q;
  assign tx_o      = (state_q == ST_CMD) ? READ_OP : 8'h00;
  assign cs_no     = !reading;
  assign done_o    = (state_q == ST_DONE);
  assign error_o   = (state_q == ST_ERR);
  assign entry_o   = entry_q;
  assign addr_last = addr24_i ? IDX_W'(2) : IDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      wait_q    <= 1'b0;
      lo_q      <= '0;
      cnt_q     <= '0;
      dest_q    <= '0;
      entry_q   <= '0;
      presc_o   <= '0;
      baud_o    <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (go_o) wait_q <= 1'b1;
      if (!reading) begin
        if (start_i) begin
          state_q <= ST_CMD;
          idx_q   <= '0;
          wait_q  <= 1'b0;
          entry_q <= '0;
        end
      end else if (rx_valid_i) begin
        wait_q <= 1'b0;
        idx_q  <= idx_q + IDX_W'(1);
        case (state_q)
          ST_CMD: begin
            state_q <= ST_ADDR;
            idx_q   <= '0;
          end
          ST_ADDR: if (idx_q == addr_last) begin
            state_q <= ST_KEY;
            idx_q   <= '0;
          end
          ST_KEY: begin
            lo_q <= rx_i;
            if (idx_q != '0) begin
              idx_q   <= '0;
              state_q <= ({rx_i, lo_q} == BOOT_KEY) ? ST_CLK : ST_ERR;
            end
          end
          ST_CLK: begin
            if (idx_q == '0) presc_o <= rx_i;
            else begin
              baud_o  <= rx_i;
              state_q <= ST_RSVD;
              idx_q   <= '0;
            end
          end
          ST_RSVD: if (idx_q == IDX_W'(RSVD_BYTES - 1)) begin
            state_q <= ST_ENTRY;
            idx_q   <= '0;
          end
          ST_ENTRY: begin
            case (idx_q)
              IDX_W'(0): entry_q[23:16] <= rx_i;
              IDX_W'(1): begin
                entry_q[31:24] <= rx_i;
                if (rx_i != 8'h00) state_q <= ST_ERR;
              end
              IDX_W'(2): entry_q[7:0] <= rx_i;
              default: begin
                entry_q[15:8] <= rx_i;
                state_q       <= ST_CNT;
                idx_q         <= '0;
              end
            endcase
          end
          ST_CNT: begin
            if (idx_q == '0) cnt_q[7:0] <= rx_i;
            else begin
              cnt_q[15:8] <= rx_i;
              idx_q       <= '0;
              state_q     <= ({rx_i, cnt_q[7:0]} == 16'h0) ? ST_DONE : ST_DEST;
            end
          end
          ST_DEST: begin
            case (idx_q)
              IDX_W'(0): dest_q[23:16] <= rx_i;
              IDX_W'(1): dest_q[31:24] <= rx_i;
              IDX_W'(2): dest_q[7:0]   <= rx_i;
              default: begin
                dest_q[15:8] <= rx_i;
                state_q      <= ST_DATA;
                idx_q        <= '0;
              end
            endcase
          end
          ST_DATA: begin
            if (idx_q == '0) lo_q <= rx_i;
            else begin
              wr_en_o   <= 1'b1;
              wr_addr_o <= dest_q;
              wr_data_o <= {rx_i, lo_q};
              dest_q    <= dest_q + 32'd1;
              cnt_q     <= cnt_q - 16'd1;
              idx_q     <= '0;
              if (cnt_q == 16'd1) state_q <= ST_CNT;
            end
          end
          default: state_q <= ST_ERR;
        endcase
      end
    end
  end

  // R9
  wr_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !cs_no);
  // R11
  done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));
  // R11
  error_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && !start_i) |=> error_o);
  // R11
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  // R10
  done_on_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(rx_valid_i));
  // R4
  error_on_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> $past(rx_valid_i));
endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader #(
  parameter int SCK_HALF_CYCLES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        addr24_i,
  output logic        sclk_o,
  output logic        cs_no,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        wr_en_o,
  output logic [31:0] wr_addr_o,
  output logic [15:0] wr_data_o,
  output logic        done_o,
  output logic        error_o,
  output logic [31:0] entry_o,
  output logic [7:0]  presc_o,
  output logic [7:0]  baud_o
);
  logic       go, ready, rx_valid;
  logic [7:0] tx_byte, rx_byte;

  spi_byte_engine #(.HALF_DIV(SCK_HALF_CYCLES)) i_engine (
    .clk_i, .rst_ni,
    .go_i(go), .tx_i(tx_byte), .ready_o(ready),
    .rx_o(rx_byte), .rx_valid_o(rx_valid),
    .sclk_o, .mosi_o, .miso_i
  );

  boot_stream_parser i_parser (
    .clk_i, .rst_ni, .start_i, .addr24_i,
    .ready_i(ready), .rx_valid_i(rx_valid), .rx_i(rx_byte),
    .go_o(go), .tx_o(tx_byte), .cs_no,
    .wr_en_o, .wr_addr_o, .wr_data_o,
    .done_o, .error_o, .entry_o, .presc_o, .baud_o
  );
endmodule

// File: tb/test_spi_boot_loader.sv
module test_spi_boot_loader;
  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, addr24_i = 1'b0;
  logic        sclk_o, cs_no, mosi_o, wr_en_o, done_o, error_o;
  logic        miso_i = 1'b0;
  logic [31:0] wr_addr_o, entry_o;
  logic [15:0] wr_data_o;
  logic [7:0]  presc_o, baud_o;

  spi_boot_loader i_spi_boot_loader (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, n_wr = 0, cyc = 0;
  logic [7:0]  img [0:255];
  int          img_len = 0;
  logic [47:0] exp_q [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // serial memory model: answers after the command and address bytes
  int          bitcnt = 0, last_bits = 0, hdr_bytes;
  logic [31:0] hdr_sh = '0, last_hdr = '0;
  assign hdr_bytes = addr24_i ? 4 : 3;

  always @(negedge sclk_o or posedge cs_no) begin
    if (cs_no) begin
      last_bits <= bitcnt;
      last_hdr  <= hdr_sh;
      bitcnt    <= 0;
      hdr_sh    <= '0;
    end else begin
      if (bitcnt < 8 * hdr_bytes) hdr_sh <= {hdr_sh[30:0], mosi_o};
      bitcnt <= bitcnt + 1;
    end
  end

  always @(posedge sclk_o) begin
    int bi;
    bi = bitcnt / 8 - hdr_bytes;
    if (bi >= 0 && bi < 256) miso_i <= img[bi][7 - (bitcnt % 8)];
    else miso_i <= 1'b0;
  end

  // scoreboard monitor
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni && wr_en_o) begin
      n_wr++;
      if (exp_q.size() == 0)
        check(0, "R9", "unexpected write addr", wr_addr_o, 32'h0);
      else begin
        logic [47:0] e;
        e = exp_q.pop_front();
        check(wr_addr_o == e[47:16], "R9", "write addr", wr_addr_o, e[47:16]);
        check(wr_data_o == e[15:0], "R9", "write data", {16'h0, wr_data_o}, {16'h0, e[15:0]});
      end
    end
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
    img_len = 0;
    exp_q.delete();
    n_wr = 0;
  endtask
  task automatic put8(input logic [7:0] b);
    img[img_len] = b; img_len++;
  endtask
  task automatic put16(input logic [15:0] w);
    put8(w[7:0]); put8(w[15:8]);
  endtask
  task automatic put32(input logic [31:0] v);
    put16(v[31:16]); put16(v[15:0]);
  endtask
  task automatic header(input logic [15:0] key, input logic [7:0] pr, input logic [7:0] bd,
                        input logic [7:0] junk, input logic [31:0] ent);
    put16(key); put8(pr); put8(bd);
    for (int i = 0; i < 14; i++) put8(junk ^ 8'(i * 37));
    put32(ent);
  endtask
  task automatic add_block(input int n, input logic [31:0] a, input logic [15:0] base);
    put16(16'(n)); put32(a);
    for (int i = 0; i < n; i++) begin
      logic [15:0] d;
      d = base + 16'(i * 16'h0111);
      put16(d);
      exp_q.push_back({a + 32'(i), d});
    end
  endtask

  task automatic run_load(input bit a24);
    addr24_i = a24;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    check(cs_no == 1'b0, "R3", "cs low after start", {31'h0, cs_no}, 32'h0);
    while (!done_o && !error_o && cyc < 150000) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    #1;
    check(cs_no && !sclk_o && !done_o && !error_o && !wr_en_o, "R1", "in reset",
          {27'h0, cs_no, sclk_o, done_o, error_o, wr_en_o}, 32'h10);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    check(cs_no && !sclk_o && !done_o && !error_o && !wr_en_o, "R1", "idle after reset",
          {27'h0, cs_no, sclk_o, done_o, error_o, wr_en_o}, 32'h10);

    // two blocks, 16-bit addressing, reserved bytes carry junk
    clear_img();
    header(16'h08AA, 8'h11, 8'h7F, 8'hC3, 32'h0012_3456);
    add_block(3, 32'h0000_1000, 16'hBEEF);
    add_block(2, 32'h0002_0040, 16'h1234);
    put16(16'h0000);
    run_load(1'b0);
    check(done_o && !error_o, "R10", "done after two blocks", {30'h0, done_o, error_o}, 32'h2);
    check(entry_o == 32'h0012_3456, "R7", "entry order", entry_o, 32'h0012_3456);
    check(presc_o == 8'h11, "R5", "prescaler", {24'h0, presc_o}, 32'h11);
    check(baud_o == 8'h7F, "R5", "baud byte", {24'h0, baud_o}, 32'h7F);
    check(last_hdr == 32'h0003_0000, "R3", "16-bit header", last_hdr, 32'h0003_0000);
    check(last_bits == 8 * (3 + img_len), "R2", "clock count one window", last_bits, 8 * (3 + img_len));
    check(n_wr == 5 && exp_q.size() == 0, "R9", "write count", n_wr, 5);
    repeat (100) @(negedge clk_i);
    check(done_o && !error_o && cs_no, "R11", "done held", {29'h0, done_o, error_o, cs_no}, 32'h5);

    // same image with other reserved content: outputs unchanged (R6), 24-bit addressing
    clear_img();
    header(16'h08AA, 8'h11, 8'h7F, 8'h00, 32'h0012_3456);
    add_block(3, 32'h0000_1000, 16'hBEEF);
    add_block(2, 32'h0002_0040, 16'h1234);
    put16(16'h0000);
    run_load(1'b1);
    check(done_o && entry_o == 32'h0012_3456 && presc_o == 8'h11 && baud_o == 8'h7F,
          "R6", "reserved bytes ignored", entry_o, 32'h0012_3456);
    check(last_hdr == 32'h0300_0000, "R3", "24-bit header", last_hdr, 32'h0300_0000);
    check(last_bits == 8 * (4 + img_len), "R10", "whole image read", last_bits, 8 * (4 + img_len));
    check(n_wr == 5 && exp_q.size() == 0, "R9", "write count 24-bit", n_wr, 5);

    // bad key
    clear_img();
    header(16'h09AA, 8'h22, 8'h33, 8'h5A, 32'h0000_0100);
    add_block(1, 32'h0000_0010, 16'hAAAA);
    exp_q.delete();
    put16(16'h0000);
    run_load(1'b0);
    check(error_o && !done_o && cs_no, "R4", "key error", {29'h0, error_o, done_o, cs_no}, 32'h5);
    check(last_bits == 8 * (3 + 2), "R4", "stop after key", last_bits, 40);
    check(n_wr == 0, "R4", "no writes on key error", n_wr, 0);
    repeat (100) @(negedge clk_i);
    check(error_o && !done_o, "R11", "error held", {30'h0, error_o, done_o}, 32'h2);

    // nonzero entry top byte
    clear_img();
    header(16'h08AA, 8'h01, 8'h02, 8'h77, 32'h0100_2000);
    add_block(1, 32'h0000_0010, 16'h5555);
    exp_q.delete();
    put16(16'h0000);
    run_load(1'b0);
    check(error_o && !done_o, "R8", "entry top byte error", {30'h0, error_o, done_o}, 32'h2);
    check(last_bits == 8 * (3 + 20), "R8", "stop after byte 20", last_bits, 8 * 23);
    check(n_wr == 0, "R8", "no writes", n_wr, 0);

    // empty chain: zero count right after entry point
    clear_img();
    header(16'h08AA, 8'hA5, 8'h5A, 8'h99, 32'h00FE_DCBA);
    put16(16'h0000);
    run_load(1'b0);
    check(done_o && !error_o, "R10", "done on empty chain", {30'h0, done_o, error_o}, 32'h2);
    check(entry_o == 32'h00FE_DCBA, "R7", "entry second pattern", entry_o, 32'h00FE_DCBA);
    check(n_wr == 0, "R10", "no writes on empty chain", n_wr, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule